// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Access Controller

This controller sits between a single-transaction host port and a 2M x 32 asynchronous DRAM. The DRAM has multiplexed address pins, two row strobes (one per bank), four column strobes (one per byte lane) and one shared write enable. Each host request carries a 21-bit word address, 32-bit write data and four byte enables. The controller turns it into a row-open, column-strobe sequence. After an access the row stays open. A later request to the same bank and row is then served with a column strobe only (page hit). A request to any other row first precharges the bank.

All writes are early writes: write enable and the data-bus drive are set a full cycle before any column strobe falls. The DRAM outputs therefore never turn on during a write. Read data is captured at the first clock edge after the worst-case access time. That time is derived from nanosecond parameters and the clock period. A refresh requester can ask for the bus. It gets a grant only once every row strobe is high and the precharge time has passed. An open row is also closed after a configurable number of cycles.

States: `S_IDLE` (no row open, precharged), `S_ROWSET` (row address set up), `S_RCD` (row strobe low, RAS-to-CAS wait), `S_COLSET` (column address, write enable and write data set up), `S_CAS` (column strobes low, read sampled at exit), `S_OPEN` (row held open, waiting), `S_PRE` (row strobe high for the precharge time), `S_REFGNT` (bus granted to the refresh requester). Transitions:
- IDLE->REFGNT on refresh request.
- IDLE->ROWSET on accepted request.
- ROWSET->RCD after one cycle.
- RCD->COLSET when the wait expires.
- COLSET->CAS after one cycle.
- CAS->OPEN when the strobe phase expires.
- OPEN->COLSET on an accepted page hit.
- OPEN->PRE on refresh request, age limit or row miss.
- PRE->IDLE when precharge expires.
- REFGNT->IDLE when the refresh request drops.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The address splits as bank = `req_addr[20]`, row = `req_addr[20:10]`, column = `req_addr[9:0]`. When a row opens, `dram_ras_n[bank]` alone falls, with the row on `dram_addr`. When the column strobes fall, `dram_addr` carries {1'b0, column}.
- R2: During the strobe phase, `dram_cas_n[i]` is low exactly when byte enable i of the accepted request is 1, for reads and writes alike.
- R3: For a write, `dram_we_n` is low and `dram_dq_oe` is high in the cycle before the column strobes fall, and stay so while they are low. `dram_dq_oe` is never high unless `dram_we_n` is low.
- R4: For a read, `dram_we_n` is high in the cycle before the column strobes fall. `rd_data` takes `dram_dq_in` at the clock edge that ends the strobe phase, which lasts enough cycles to cover the access times from row strobe, column strobe and column address. `rd_valid` is a one-cycle pulse.
- R5: The column strobes never fall in the same cycle as the row strobe. Every row strobe fall comes after at least ceil(T_RP_NS/CLK_NS) cycles (3 by default) with all row strobes high.
- R6: A request whose bank and row match the open row is served without the row strobe rising. An idle open row stays open below the age limit.
- R7: A request to another row closes the open row (precharge), then opens the new one.
- R8: While `ref_req` is high no request is accepted. An open row is closed, and `ref_gnt` rises only with all row strobes high after precharge. `ref_gnt` stays high until `ref_req` falls.
- R9: A row left open for OPEN_MAX_CYC cycles (64 by default) is closed. No row strobe stays low longer than that limit plus one access.
- R10: During and right after reset: all strobes high, `dram_we_n` high, `dram_dq_oe` low, `rd_valid` low, `ref_gnt` low, `req_ready` high.
- R11: Only one transaction is outstanding. `req_ready` is low from the accepting edge until the access has finished its strobe phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address {row, column}, MSB is bank |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, one per column strobe |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data |
| ref_req | input | 1 | Refresh requester wants the DRAM |
| ref_gnt | output | 1 | DRAM released and precharged |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 2 | Row strobes, one per bank |
| dram_cas_n | output | 4 | Column strobes, one per byte lane |
| dram_we_n | output | 1 | Write enable |
| dram_dq_out | output | 32 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Data bus drive enable |
| dram_dq_in | input | 32 | Data returned by the DRAM |

## Verification
A page hit and a refresh request can arrive together while a row is open. Both reach `S_OPEN` in the same cycle, and refresh must win. The bench holds a matching read request and raises `ref_req` on the same edge. It then judges that `req_ready` stays low, that the row closes and precharges before `ref_gnt` rises, and that the held request afterwards opens the row again and returns the stored word. A behavioural DRAM model in the bench checks strobe order, address multiplexing, lane strobes and early-write setup on every access. It returns valid data only after the access time, so a short strobe phase reads back a wrong word.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROWSET,
        S_RCD,
        S_COLSET,
        S_CAS,
        S_OPEN,
        S_PRE,
        S_REFGNT
    } fpm_state_e;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_phase_timer.sv
module fpm_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    p_cnt_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/fpm_row_tracker.sv
module fpm_row_tracker #(
    parameter int ROW_W        = 11,
    parameter int OPEN_MAX_CYC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             hit_o,
    output logic             aged_o
);
    localparam int AGE_W = $clog2(OPEN_MAX_CYC + 1);

    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            row_q  <= '0;
            age_q  <= '0;
        end else if (open_i) begin
            open_q <= 1'b1;
            row_q  <= row_i;
            age_q  <= '0;
        end else if (close_i) begin
            open_q <= 1'b0;
            age_q  <= '0;
        end else if (open_q && !aged_o) begin
            age_q  <= age_q + 1'b1;
        end
    end

    assign hit_o  = open_q && (row_q == row_i);
    assign aged_o = open_q && (age_q >= AGE_W'(OPEN_MAX_CYC));

    p_age_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        age_q <= AGE_W'(OPEN_MAX_CYC));

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
    parameter int CLK_NS       = 20,
    parameter int T_RCD_NS     = 20,
    parameter int T_RAC_NS     = 70,
    parameter int T_CAC_NS     = 20,
    parameter int T_AA_NS      = 35,
    parameter int T_CPA_NS     = 40,
    parameter int T_CAS_NS     = 20,
    parameter int T_RP_NS      = 50,
    parameter int OPEN_MAX_CYC = 64,
    parameter int ROW_W        = 11,
    parameter int COL_W        = 10,
    parameter int DATA_W       = 32,
    parameter int RAS_LINES    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [ROW_W+COL_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [DATA_W/8-1:0]     req_be,
    output logic                    rd_valid,
    output logic [DATA_W-1:0]       rd_data,
    input  logic                    ref_req,
    output logic                    ref_gnt,
    output logic [ROW_W-1:0]        dram_addr,
    output logic [RAS_LINES-1:0]    dram_ras_n,
    output logic [DATA_W/8-1:0]     dram_cas_n,
    output logic                    dram_we_n,
    output logic [DATA_W-1:0]       dram_dq_out,
    output logic                    dram_dq_oe,
    input  logic [DATA_W-1:0]       dram_dq_in
);
    import fpm_pkg::*;

    localparam int ADDR_W  = ROW_W + COL_W;
    localparam int LANES   = DATA_W / 8;
    localparam int BANK_W  = $clog2(RAS_LINES);
    localparam int RCD_CYC = imax(1, cdiv(T_RCD_NS, CLK_NS));
    // strobe phase: covers access from column strobe, column address
    // (set one cycle earlier), row strobe and page precharge (>=2 cycles high)
    localparam int CAS_CYC = imax(1, imax(
                                 imax(cdiv(T_CAC_NS, CLK_NS), cdiv(T_AA_NS, CLK_NS) - 1),
                                 imax(cdiv(T_RAC_NS, CLK_NS) - RCD_CYC - 1,
                                      imax(cdiv(T_CAS_NS, CLK_NS), cdiv(T_CPA_NS, CLK_NS) - 2))));
    localparam int RP_CYC  = imax(1, cdiv(T_RP_NS, CLK_NS));
    localparam int TMR_MAX = imax(RCD_CYC, imax(CAS_CYC, RP_CYC));
    localparam int TMR_W   = imax(1, $clog2(TMR_MAX + 1));
    localparam int RAGE_W  = $clog2(OPEN_MAX_CYC + 4 * TMR_MAX + 8) + 1;

    fpm_state_e state_q, state_d;

    logic              q_write;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_wdata;
    logic [LANES-1:0]  q_be;
    logic [BANK_W-1:0] q_bank;

    logic             accept;
    logic             tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic             row_hit, row_aged, ras_act;

    assign q_bank = q_addr[ADDR_W-1 -: BANK_W];
    assign accept = req_valid && req_ready;

    fpm_phase_timer #(.CNT_W(TMR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    fpm_row_tracker #(.ROW_W(ROW_W), .OPEN_MAX_CYC(OPEN_MAX_CYC)) u_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_i  (accept && state_q == S_IDLE),
        .close_i (state_d == S_PRE && state_q != S_PRE),
        .row_i   (req_addr[ADDR_W-1:COL_W]),
        .hit_o   (row_hit),
        .aged_o  (row_aged)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and phase timer loading
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (ref_req)       state_d = S_REFGNT;
                      else if (accept)   state_d = S_ROWSET;
            S_ROWSET:                    state_d = S_RCD;
            S_RCD:    if (tmr_zero)      state_d = S_COLSET;
            S_COLSET:                    state_d = S_CAS;
            S_CAS:    if (tmr_zero)      state_d = S_OPEN;
            S_OPEN:   if (ref_req || row_aged)   state_d = S_PRE;
                      else if (accept)           state_d = S_COLSET;
                      else if (req_valid)        state_d = S_PRE;
            S_PRE:    if (tmr_zero)      state_d = S_IDLE;
            S_REFGNT: if (!ref_req)      state_d = S_IDLE;
        endcase
        tmr_load = (state_d != state_q);
        unique case (state_d)
            S_RCD:   tmr_val = TMR_W'(RCD_CYC - 1);
            S_CAS:   tmr_val = TMR_W'(CAS_CYC - 1);
            S_PRE:   tmr_val = TMR_W'(RP_CYC - 1);
            default: tmr_val = '0;
        endcase
    end

    // request latch and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_write  <= 1'b0;
            q_addr   <= '0;
            q_wdata  <= '0;
            q_be     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (accept) begin
                q_write <= req_write;
                q_addr  <= req_addr;
                q_wdata <= req_wdata;
                q_be    <= req_be;
            end
            rd_valid <= (state_q == S_CAS) && tmr_zero && !q_write;
            if ((state_q == S_CAS) && tmr_zero && !q_write)
                rd_data <= dram_dq_in;
        end
    end

    // DRAM pin and handshake outputs
    always_comb begin
        req_ready   = 1'b0;
        ref_gnt     = 1'b0;
        ras_act     = 1'b0;
        dram_addr   = '0;
        dram_cas_n  = '1;
        dram_we_n   = 1'b1;
        dram_dq_oe  = 1'b0;
        dram_dq_out = q_wdata;
        unique case (state_q)
            S_IDLE:   req_ready = !ref_req;
            S_ROWSET: dram_addr = q_addr[ADDR_W-1:COL_W];
            S_RCD: begin
                ras_act   = 1'b1;
                dram_addr = q_addr[ADDR_W-1:COL_W];
            end
            S_COLSET, S_CAS: begin
                ras_act    = 1'b1;
                dram_addr  = ROW_W'(q_addr[COL_W-1:0]);
                dram_we_n  = !q_write;
                dram_dq_oe = q_write;
                if (state_q == S_CAS) dram_cas_n = ~q_be;
            end
            S_OPEN: begin
                ras_act   = 1'b1;
                dram_addr = ROW_W'(q_addr[COL_W-1:0]);
                req_ready = !ref_req && !row_aged && row_hit;
            end
            S_PRE:    ;
            S_REFGNT: ref_gnt = 1'b1;
        endcase
    end

    for (genvar b = 0; b < RAS_LINES; b++) begin : g_ras
        assign dram_ras_n[b] = !(ras_act && q_bank == BANK_W'(b));
    end

    // row-strobe low time monitor for the age bound
    logic [RAGE_W-1:0] ras_low_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                ras_low_cnt <= '0;
        else if (&dram_ras_n)      ras_low_cnt <= '0;
        else                       ras_low_cnt <= ras_low_cnt + 1'b1;
    end

    p_one_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dram_ras_n));
    p_oe_needs_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> !dram_we_n);
    p_early_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&dram_cas_n) && $past(&dram_cas_n) && !dram_we_n)
            |-> ($past(!dram_we_n) && $past(dram_dq_oe)));
    p_read_we_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&dram_cas_n) && $past(&dram_cas_n) && dram_we_n) |-> $past(dram_we_n));
    p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    p_cas_after_ras_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(&dram_cas_n) |-> ($past(!(&dram_ras_n)) && !(&dram_ras_n)));
    p_gnt_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> (&dram_ras_n));
    p_ref_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |-> !req_ready);
    p_ras_age_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ras_low_cnt <= RAGE_W'(OPEN_MAX_CYC + 2 * TMR_MAX + 4));
    p_single_txn_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/tb_fpm_dram_ctrl.sv
module tb_fpm_dram_ctrl;

    localparam int RP_BENCH = 3;   // ceil(50 ns / 20 ns)
    localparam int NV       = 12;
    // {write, addr[20:0], wdata, be, expected read, expected row opening}
    localparam logic [90:0] VEC [NV] = '{
        {1'b1, 21'h000005, 32'hA5A50001, 4'hF, 32'h00000000, 1'b1},
        {1'b1, 21'h000006, 32'h12345678, 4'hF, 32'h00000000, 1'b0},
        {1'b0, 21'h000005, 32'h00000000, 4'hF, 32'hA5A50001, 1'b0},
        {1'b0, 21'h000006, 32'h00000000, 4'hF, 32'h12345678, 1'b0},
        {1'b1, 21'h000406, 32'hCAFEBABE, 4'hF, 32'h00000000, 1'b1},
        {1'b0, 21'h000006, 32'h00000000, 4'hF, 32'h12345678, 1'b1},
        {1'b1, 21'h000006, 32'hFFFF0000, 4'h3, 32'h00000000, 1'b0},
        {1'b0, 21'h000006, 32'h00000000, 4'hF, 32'h12340000, 1'b0},
        {1'b1, 21'h100006, 32'h0BADF00D, 4'hF, 32'h00000000, 1'b1},
        {1'b0, 21'h100006, 32'h00000000, 4'hF, 32'h0BADF00D, 1'b0},
        {1'b0, 21'h000406, 32'h00000000, 4'hF, 32'hCAFEBABE, 1'b1},
        {1'b0, 21'h100006, 32'h00000000, 4'hF, 32'h0BADF00D, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
    logic [20:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_ready, rd_valid, ref_gnt, dram_we_n, dram_dq_oe;
    logic [31:0] rd_data, dram_dq_out;
    logic [31:0] dram_dq_in = '0;
    logic [10:0] dram_addr;
    logic [1:0]  dram_ras_n;
    logic [3:0]  dram_cas_n;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    fpm_dram_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .ref_req(ref_req), .ref_gnt(ref_gnt),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural DRAM model ----------------
    logic        cur_write = 1'b0;
    logic [20:0] cur_addr = '0;
    logic [3:0]  cur_be = '0;
    int          n_opens = 0, n_cas = 0, ras_hi = 100, cas_cnt = 0;
    logic        p_ras = 1'b0, p_cas = 1'b0, p_we = 1'b1, p_oe = 1'b0;
    logic [10:0] m_row = '0;
    logic [9:0]  m_col = '0;
    logic [31:0] mem [int];

    always @(negedge clk) begin
        if (rst_n) begin
            logic any_ras, any_cas;
            int   key;
            logic [31:0] w;
            any_ras = ~&dram_ras_n;
            any_cas = ~&dram_cas_n;
            if (any_ras && !p_ras) begin
                n_opens++;
                chk(ras_hi >= RP_BENCH, "R5 precharge", ras_hi, RP_BENCH);
                chk(dram_addr == cur_addr[20:10], "R1 row", dram_addr, cur_addr[20:10]);
                chk(dram_ras_n == ~(2'b01 << cur_addr[20]), "R1 bank", dram_ras_n,
                    ~(2'b01 << cur_addr[20]));
                m_row = dram_addr;
            end
            ras_hi = any_ras ? 0 : ras_hi + 1;
            if (any_cas && !p_cas) begin
                n_cas++;
                cas_cnt = 0;
                chk(p_ras && any_ras, "R5 ras before cas", p_ras, 1);
                chk(dram_cas_n == ~cur_be, "R2 lanes", dram_cas_n, ~cur_be);
                chk(dram_addr == {1'b0, cur_addr[9:0]}, "R1 column", dram_addr,
                    {1'b0, cur_addr[9:0]});
                if (cur_write) chk(!p_we && p_oe, "R3 early write", {p_we, p_oe}, 2'b01);
                else           chk(p_we, "R4 read we", p_we, 1);
                m_col = dram_addr[9:0];
            end
            if (any_cas) begin
                cas_cnt++;
                key = int'({m_row, m_col});
                w = mem.exists(key) ? mem[key] : 32'h0;
                if (!dram_we_n) begin
                    chk(dram_dq_oe, "R3 oe during write", dram_dq_oe, 1);
                    for (int l = 0; l < 4; l++)
                        if (!dram_cas_n[l]) w[l*8 +: 8] = dram_dq_out[l*8 +: 8];
                    mem[key] = w;
                end else begin
                    chk(!dram_dq_oe, "R3 oe during read", dram_dq_oe, 0);
                    dram_dq_in <= (cas_cnt >= 2) ? w : 32'hBAD0BAD0;
                end
            end else begin
                dram_dq_in <= 32'h0;
            end
            p_ras = any_ras; p_cas = any_cas; p_we = dram_we_n; p_oe = dram_dq_oe;
        end
    end

    // ---------------- host transaction ----------------
    task automatic run_txn(input logic w, input logic [20:0] a, input logic [31:0] d,
                           input logic [3:0] be, output logic [31:0] rdata,
                           output int opens);
        int  o0, c0;
        bit  ok;
        o0 = n_opens; c0 = n_cas; rdata = '0;
        cur_write = w; cur_addr = a; cur_be = be;
        req_write = w; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
        ok = 0;
        for (int i = 0; i < 300; i++) begin
            #1;
            if (req_ready) begin ok = 1; break; end
            @(negedge clk);
        end
        chk(ok, "R11 accept", ok, 1);
        @(posedge clk); #1 req_valid = 1'b0;
        @(negedge clk); #1;
        chk(!req_ready, "R11 single outstanding", req_ready, 0);
        for (int i = 0; i < 50 && n_cas == c0; i++) @(negedge clk);
        if (!w) begin
            ok = 0;
            for (int i = 0; i < 50; i++) begin
                @(negedge clk); #1;
                if (rd_valid) begin ok = 1; rdata = rd_data; break; end
            end
            chk(ok, "R4 rd_valid", ok, 1);
            @(negedge clk); #1;
            chk(!rd_valid, "R4 rd_valid pulse", rd_valid, 0);
        end
        repeat (2) @(negedge clk);
        opens = n_opens - o0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          op;
        // R10 reset state, during and after reset
        repeat (3) @(negedge clk);
        chk({dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe} == 8'b11_1111_1_0,
            "R10 pins in reset", {dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe}, 8'hFE);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk({rd_valid, ref_gnt, req_ready} == 3'b001, "R10 handshake after reset",
            {rd_valid, ref_gnt, req_ready}, 3'b001);
        chk(dram_ras_n == 2'b11 && dram_cas_n == 4'hF, "R10 strobes after reset",
            {dram_ras_n, dram_cas_n}, 6'h3F);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [90:0] v;
            v = VEC[i];
            run_txn(v[90], v[89:69], v[68:37], v[36:33], rd, op);
            if (v[0]) chk(op == 1, "R7 row miss opens", op, 1);
            else      chk(op == 0, "R6 page hit keeps row", op, 0);
            if (!v[90]) chk(rd == v[32:1], "R4 read data", rd, v[32:1]);
        end

        // R8: refresh and page hit in the same cycle
        @(negedge clk);
        ref_req = 1'b1;
        cur_write = 1'b0; cur_addr = 21'h100006; cur_be = 4'hF;
        req_write = 1'b0; req_addr = 21'h100006; req_be = 4'hF; req_valid = 1'b1;
        #1 chk(!req_ready, "R8 hit blocked by refresh", req_ready, 0);
        begin
            bit got;
            got = 0;
            for (int i = 0; i < 50; i++) begin
                @(negedge clk); #1;
                chk(!req_ready, "R8 no accept", req_ready, 0);
                if (ref_gnt) begin got = 1; break; end
            end
            chk(got, "R8 grant", got, 1);
        end
        chk(dram_ras_n == 2'b11, "R8 rows closed at grant", dram_ras_n, 2'b11);
        chk(ras_hi >= RP_BENCH, "R8 precharged at grant", ras_hi, RP_BENCH);
        repeat (3) begin
            @(negedge clk); #1;
            chk(ref_gnt && !req_ready, "R8 grant held", {ref_gnt, req_ready}, 2'b10);
        end
        ref_req = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        run_txn(1'b0, 21'h100006, 32'h0, 4'hF, rd, op);
        chk(op == 1, "R8 reopen after refresh", op, 1);
        chk(rd == 32'h0BADF00D, "R8 data after refresh", rd, 32'h0BADF00D);

        // R6 / R9: idle open row, then age limit
        repeat (10) @(negedge clk);
        #1 chk(dram_ras_n != 2'b11, "R6 row kept open", dram_ras_n, 2'b01);
        repeat (70) @(negedge clk);
        #1 chk(dram_ras_n == 2'b11, "R9 aged row closed", dram_ras_n, 2'b11);
        @(negedge clk);
        run_txn(1'b0, 21'h100006, 32'h0, 4'hF, rd, op);
        chk(op == 1, "R9 reopen after age close", op, 1);
        chk(rd == 32'h0BADF00D, "R9 data", rd, 32'h0BADF00D);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule